// File: doc/BRIEF.md
# Deflection Controller Serial Configuration Slave

This block is the serial-bus front end of a display deflection controller. It is an I2C slave at 7-bit address 0x46. A host writes a start subaddress and then any number of data bytes into sixteen 8-bit configuration registers. The subaddress advances after every data byte. All register contents are presented in parallel to the deflection logic on one flat output bus.

A read at the same address returns a single status byte. The byte carries a sticky power-on flag and a sticky overvoltage flag. The flags are released only by a read that the host ends correctly, which means it answers the last status byte with a not-acknowledge. While the power-on flag is set, the line-start enable bit in the main control register reads as zero on the parallel output. This keeps the line drive stopped until software has seen the flag.

SCL and SDA each pass through a two-stage synchroniser clocked by the system clock. START and STOP are recognised from SDA edges while SCL is high. The slave acknowledges by pulling SDA low through an open-drain enable.

Top module: `defl_cfg_i2c`

## Requirements
- R1: Only address byte 0x8C (write) or 0x8D (read) is acknowledged. A transfer to any other address gets no acknowledge, and its data bytes change no register.
- R2: In a write, the first byte after the address sets the subaddress. Each following data byte goes to the current subaddress, which then advances by one.
- R3: The subaddress wraps from 0Fh to 00h within a burst.
- R4: All eight bits of a written byte are stored. Register n appears on cfg_o[8n+7:8n].
- R5: The status byte carries the power-on flag in bit 7, the overvoltage flag in bit 6, and zeros in bits 5..0.
- R6: The power-on flag is set by reset and by a pulse on por_evt. It stays set through status bytes that the master acknowledges. It clears only after a status byte that the master answers with a not-acknowledge.
- R7: The overvoltage flag sets in the cycle after ovp_i is high. A completed status read clears it only if ovp_i is low at that time.
- R8: While the power-on flag is set, bit 2 of register 0Bh (line-start enable) reads 0 on cfg_o. The stored value returns once the flag clears.
- R9: After reset, every register is zero, the power-on flag is 1, the overvoltage flag is 0, and SDA is released.
- R10: A repeated START during a write restarts the address phase. The following subaddress byte sets a new write position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| por_evt | input | 1 | One-cycle supply-dip event, sets the power-on flag |
| ovp_i | input | 1 | Overvoltage condition, synchronous level |
| sda_oe | output | 1 | High to pull SDA low (acknowledge or read data 0) |
| cfg_o | output | 128 | Register n on bits [8n+7:8n]; register 0Bh bit 2 forced low while the power-on flag is set |

## Verification
The bench targets the flag-clearing rule. It reads two status bytes with an acknowledge between them, so a design that cleared on every read would return zero for the second byte. It also reads while the overvoltage condition is still high, where a design that cleared unconditionally would drop the flag. A burst that starts at 0Eh shows whether the subaddress wraps or runs past the register file. A transfer to a neighbouring address shows whether a foreign write reaches the registers. A register 0Bh written as all ones before and after the power-on flag clears shows whether line-start gating is missing or permanent.

// File: rtl/defl_cfg_i2c.sv
module defl_cfg_i2c #(
  parameter logic [6:0] DEV_ADDR   = 7'h46,
  parameter int         NREG       = 16,
  parameter int         CTRL_REG   = 11,
  parameter int         LSTART_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              por_evt,
  input  logic              ovp_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] cfg_o
);
  localparam int AW = $clog2(NREG);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} st_t;
  typedef enum logic [1:0] {K_ADDR, K_SUB, K_DATA} kind_t;

  logic [2:0]    scl_q, sda_q;
  st_t           st;
  kind_t         kind;
  logic          rw, mnack, pon_q, prot_q;
  logic [3:0]    cnt;
  logic [7:0]    sh;
  logic [AW-1:0] sub;
  logic [7:0]    regs [NREG];

  wire scl_rise  = scl_q[1] & ~scl_q[2];
  wire scl_fall  = ~scl_q[1] & scl_q[2];
  wire scl_hi    = scl_q[1] & scl_q[2];
  wire bus_start = scl_hi & ~sda_q[1] & sda_q[2];
  wire bus_stop  = scl_hi & sda_q[1] & ~sda_q[2];
  wire rd_ok     = (st == S_MACK) && scl_fall && mnack;
  wire [7:0] status = {pon_q, prot_q, 6'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 3'b111;
      sda_q  <= 3'b111;
      st     <= S_IDLE;
      kind   <= K_ADDR;
      rw     <= 1'b0;
      mnack  <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
      sub    <= '0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
      if (bus_start) begin
        st     <= S_RX;
        kind   <= K_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (bus_stop) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (scl_rise) begin
        case (st)
          S_RX: begin
            sh  <= {sh[6:0], sda_q[1]};
            cnt <= cnt + 4'd1;
          end
          S_TX:   cnt   <= cnt + 4'd1;
          S_MACK: mnack <= sda_q[1];
          default: ;
        endcase
      end else if (scl_fall) begin
        case (st)
          S_RX: if (cnt == 4'd8) begin
            if (kind == K_ADDR && sh[7:1] != DEV_ADDR) begin
              st <= S_IDLE;
            end else begin
              st     <= S_ACK;
              sda_oe <= 1'b1;
              if (kind == K_ADDR) rw <= sh[0];
              if (kind == K_SUB)  sub <= sh[AW-1:0];
              if (kind == K_DATA) begin
                regs[sub] <= sh;
                sub       <= sub + 1'b1;
              end
            end
          end
          S_ACK: begin
            cnt <= '0;
            if (rw && kind == K_ADDR) begin
              st     <= S_TX;
              sda_oe <= ~status[7];
              sh     <= {status[6:0], 1'b0};
            end else begin
              st     <= S_RX;
              sda_oe <= 1'b0;
              kind   <= (kind == K_ADDR) ? K_SUB : K_DATA;
            end
          end
          S_TX: if (cnt == 4'd8) begin
            st     <= S_MACK;
            sda_oe <= 1'b0;
          end else begin
            sda_oe <= ~sh[7];
            sh     <= {sh[6:0], 1'b0};
          end
          S_MACK: if (mnack) begin
            st <= S_IDLE;
          end else begin
            st     <= S_TX;
            cnt    <= '0;
            sda_oe <= ~status[7];
            sh     <= {status[6:0], 1'b0};
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pon_q  <= 1'b1;
      prot_q <= 1'b0;
    end else begin
      if (por_evt)    pon_q <= 1'b1;
      else if (rd_ok) pon_q <= 1'b0;
      if (ovp_i)      prot_q <= 1'b1;
      else if (rd_ok) prot_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    if (g == CTRL_REG) begin : g_ctrl
      assign cfg_o[g*8 +: 8] = pon_q ? (regs[g] & ~(8'd1 << LSTART_BIT)) : regs[g];
    end else begin : g_plain
      assign cfg_o[g*8 +: 8] = regs[g];
    end
  end
endmodule

module defl_cfg_chk (
  input logic clk,
  input logic rst_n,
  input logic por_evt,
  input logic ovp_i,
  input logic pon_q,
  input logic prot_q,
  input logic rd_ok,
  input logic lstart,
  input logic sda_oe,
  input logic scl_fall,
  input logic bus_evt
);
  // R8
  lstart_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pon_q |-> !lstart);
  // R6
  pon_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_evt |=> pon_q);
  // R6
  pon_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pon_q && !rd_ok |=> pon_q);
  // R7
  prot_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_i |=> prot_q);
  // R7
  prot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_q) |-> !$past(ovp_i));
  // R1
  sda_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(bus_evt)));
endmodule

bind defl_cfg_i2c defl_cfg_chk chk_i (
  .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .ovp_i(ovp_i),
  .pon_q(pon_q), .prot_q(prot_q), .rd_ok(rd_ok),
  .lstart(cfg_o[CTRL_REG*8+LSTART_BIT]), .sda_oe(sda_oe),
  .scl_fall(scl_fall), .bus_evt(bus_start | bus_stop)
);

// File: tb/defl_cfg_i2c_tb.sv
module defl_cfg_i2c_tb_top;
  localparam int CLK_NS = 10;
  localparam int Q = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic por_evt = 1'b0, ovp_i = 1'b0;
  logic sda_oe;
  logic [127:0] cfg_o;
  wire sda_line = sda_m & ~sda_oe;

  int errors = 0, checks = 0;
  bit cmp_en = 1'b0, done = 1'b0;
  logic [7:0] mreg [16];
  logic pon_m = 1'b1, prot_m = 1'b0;

  defl_cfg_i2c dut_i (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .por_evt(por_evt), .ovp_i(ovp_i), .sda_oe(sda_oe), .cfg_o(cfg_o));

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [127:0] exp_cfg();
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = mreg[i];
    if (pon_m) v[11*8+2] = 1'b0;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R4 R8: reference register image compared on every clock between transfers
  always @(negedge clk) if (cmp_en) begin
    checks++;
    if (cfg_o !== exp_cfg()) begin
      errors++;
      $display("FAIL R4/R8 cfg actual=%h expected=%h", cfg_o, exp_cfg());
    end
  end

  task automatic w(input int n); repeat (n) @(posedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(2*Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int k = 7; k >= 0; k--) begin
      sda_m = b[k]; w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0; w(Q);
    end
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); ack = sda_line; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int k = 7; k >= 0; k--) begin
      w(Q); scl_m = 1'b1; w(Q); b[k] = sda_line; w(Q); scl_m = 1'b0; w(Q);
    end
    sda_m = mack; w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic wr_burst(input int sub, input int n, input logic [7:0] base);
    logic ack;
    cmp_en = 1'b0;
    bus_start();
    put_byte(8'h8C, ack); chk("R1 write address ack", ack, 0);
    put_byte(8'(sub), ack); chk("R2 subaddress ack", ack, 0);
    for (int k = 0; k < n; k++) begin
      put_byte(base + 8'(k), ack); chk("R2 data ack", ack, 0);
      mreg[(sub + k) % 16] = base + 8'(k);
    end
    bus_stop();
    cmp_en = 1'b1; w(4);
  endtask

  task automatic rd_status(input int n);
    logic ack;
    logic [7:0] b;
    cmp_en = 1'b0;
    bus_start();
    put_byte(8'h8D, ack); chk("R1 read address ack", ack, 0);
    for (int k = 0; k < n; k++) begin
      get_byte(k == n - 1, b);
      chk("R5 R6 R7 status byte", b, {pon_m, prot_m, 6'b0});
    end
    bus_stop();
    pon_m = 1'b0;
    prot_m = ovp_i;
    cmp_en = 1'b1; w(4);
  endtask

  initial begin
    logic ack;
    for (int i = 0; i < 16; i++) mreg[i] = 8'h00;
    w(5); rst_n = 1'b1; w(5);
    chk("R9 sda released after reset", sda_oe, 0);
    cmp_en = 1'b1; w(4);
    // R8: line-start bit hidden while power-on flag set
    wr_burst(11, 1, 8'hFF);
    chk("R8 line start gated", cfg_o[11*8 +: 8], 8'hFB);
    // R6: acknowledged byte does not clear, final NACKed byte does
    rd_status(2);
    chk("R8 line start released", cfg_o[11*8 +: 8], 8'hFF);
    rd_status(1);
    // R2 R4: full burst
    wr_burst(0, 16, 8'h30);
    chk("R4 register 5 position", cfg_o[5*8 +: 8], 8'h35);
    // R3: wrap
    wr_burst(14, 4, 8'hA0);
    chk("R3 wrap to 00", cfg_o[7:0], 8'hA2);
    chk("R3 wrap to 01", cfg_o[15:8], 8'hA3);
    // R1: foreign address ignored
    cmp_en = 1'b0;
    bus_start();
    put_byte(8'h8E, ack); chk("R1 foreign address nack", ack, 1);
    put_byte(8'h03, ack); put_byte(8'h55, ack);
    bus_stop();
    cmp_en = 1'b1; w(4);
    chk("R1 register 3 untouched", cfg_o[3*8 +: 8], 8'h33);
    // R10: repeated start
    cmp_en = 1'b0;
    bus_start();
    put_byte(8'h8C, ack); put_byte(8'h05, ack);
    bus_start();
    put_byte(8'h8C, ack); chk("R10 address after repeated start", ack, 0);
    put_byte(8'h07, ack); put_byte(8'h6E, ack);
    bus_stop();
    mreg[7] = 8'h6E;
    cmp_en = 1'b1; w(4);
    chk("R10 register 7", cfg_o[7*8 +: 8], 8'h6E);
    chk("R10 register 5 kept", cfg_o[5*8 +: 8], 8'h35);
    // R6: supply dip
    cmp_en = 1'b0;
    @(negedge clk) por_evt = 1'b1;
    @(negedge clk) por_evt = 1'b0;
    pon_m = 1'b1; w(2); cmp_en = 1'b1; w(4);
    chk("R6 R8 dip gates line start", cfg_o[11*8 +: 8], 8'h3F & 8'hFB);
    rd_status(1);
    // R7: overvoltage sticky while active
    @(negedge clk) ovp_i = 1'b1;
    w(2); prot_m = 1'b1;
    rd_status(1);
    rd_status(1);
    @(negedge clk) ovp_i = 1'b0;
    w(2);
    rd_status(1);
    rd_status(1);
    chk("R7 overvoltage cleared", prot_m, 0);
    cmp_en = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule